// File: doc/BRIEF.md
# Single-Cycle Main Control and Next-PC Selection

This block is the instruction-level control of a single-cycle load/store processor. It looks at the opcode and function fields of the instruction currently being executed and produces every strobe the rest of the datapath needs. These are the register destination select, the ALU operand select, the memory strobes, the writeback source, the branch and jump strobes, and a 2-bit operation class for the ALU control. Everything is combinational. The results are meant to be registered by the program counter and the register file at the next clock edge.

The block also contains the two selection paths that depend most closely on those strobes. The first is the next-PC path. It chooses between the sequential address, a taken equal/not-equal branch, an absolute jump target and a register-held target. The second is the writeback path, which chooses the destination register number and the data written to it. For a link-jump it forces the link register and the return address. The instruction set covered is: register-register operations, word load, word store, branch-if-equal, branch-if-not-equal, jump, jump-and-link, load-upper-immediate and jump-to-register.

Top module: `sc_control_unit`

## Requirements
- R1: For opcode 000000 with a function field other than 001000, the outputs are regDst=1, regWrite=1 and aluOp=10. writeReg is instr[15:11], writeData is aluResult and nextPc is pcPlus4.
- R2: For opcode 100011, the outputs are aluSrc=1, memToReg=1, regWrite=1, memRead=1 and aluOp=00. writeReg is instr[20:16] and writeData is memData.
- R3: For opcode 101011, the outputs are aluSrc=1, memWrite=1, aluOp=00 and regWrite=0.
- R4: For opcode 000100, the outputs are branch=1 and aluOp=01. nextPc is pcPlus4 + (sign-extended instr[15:0] shifted left by 2) when zeroFlag=1, and pcPlus4 otherwise.
- R5: For opcode 000101, the outputs are branchNotEq=1, aluOp=01 and regWrite=0. The same target is taken when zeroFlag=0, and nextPc is pcPlus4 when zeroFlag=1.
- R6: For opcode 000010, the output is jump=1. nextPc is {pcPlus4[31:28], instr[25:0], 2'b00}.
- R7: For opcode 000011, the outputs are jump=1, jal=1 and regWrite=1. nextPc is the jump target of R6, writeReg is 31 and writeData is pcPlus4.
- R8: For opcode 001111, the outputs are aluSrc=1, regWrite=1 and aluOp=11, with regDst=0 and memToReg=0.
- R9: For opcode 000000 with function field 001000, the outputs are jumpReg=1, regDst=1, aluOp=10 and regWrite=0. nextPc is regRead1, and this choice overrides every other next-PC source.
- R10: Any control output not named as asserted for an instruction is 0. For any other opcode, every strobe is 0, aluOp is 00 and nextPc is pcPlus4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| pcPlus4 | input | DATA_W | Address of the sequential successor |
| zeroFlag | input | 1 | ALU result-is-zero flag |
| regRead1 | input | DATA_W | Value on register read port 1 |
| aluResult | input | DATA_W | ALU result |
| memData | input | DATA_W | Data memory read value |
| regDst | output | 1 | Destination is the rd field (else rt) |
| aluSrc | output | 1 | ALU operand B is the immediate |
| memToReg | output | 1 | Writeback takes memory data |
| regWrite | output | 1 | Register file write enable |
| memRead | output | 1 | Data memory read strobe |
| memWrite | output | 1 | Data memory write strobe |
| branch | output | 1 | Branch when equal |
| branchNotEq | output | 1 | Branch when not equal |
| jump | output | 1 | Absolute jump |
| jal | output | 1 | Link: force link register and return address |
| jumpReg | output | 1 | Jump to register value |
| aluOp | output | 2 | ALU class: 00 add, 01 subtract, 10 function field, 11 upper immediate |
| nextPc | output | DATA_W | Selected next program counter |
| writeReg | output | 5 | Register file write address |
| writeData | output | DATA_W | Register file write data |

## Verification
The bench drives both equal and not-equal conditions into each branch kind. A design with the zero-flag polarity swapped on either path would follow the wrong branch, and a design that shares one path would take branch-if-not-equal on equality. Jump-to-register is exercised with a random branch and jump context, so a register-target mux placed before the branch mux, or a write left enabled, shows up as a wrong nextPc or a stray regWrite. The link-jump cases use random rt/rd fields and ALU/memory data, which exposes writeback overrides that are missing or applied before the wrong mux. All 64 opcodes are also swept, to catch opcodes that are not used by the instruction set but still raise a strobe.

// File: rtl/sc_ctl_pkg.sv
package sc_ctl_pkg;
  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_LINK  = 6'b000011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_UPPER = 6'b001111;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] FN_JREG  = 6'b001000;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;
  localparam logic [1:0] ALU_UPPER = 2'b11;

  // full decoder output
  typedef struct packed {
    logic       regDst;
    logic       aluSrc;
    logic       memToReg;
    logic       regWrite;
    logic       memRead;
    logic       memWrite;
    logic       branch;
    logic       branchNotEq;
    logic       jump;
    logic       jal;
    logic       jumpReg;
    logic [1:0] aluOp;
  } ctrl_t;

  // strobes the datapath consumes
  typedef struct packed {
    logic regDst;
    logic memToReg;
    logic branch;
    logic branchNotEq;
    logic jump;
    logic jal;
    logic jumpReg;
  } dp_strobe_t;
endpackage

// File: rtl/sc_main_decoder.sv
module sc_main_decoder
  import sc_ctl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  logic known;

  always_comb begin
    ctrl  = '0;
    known = 1'b1;
    case (opcode)
      OP_REG: begin
        ctrl.regDst = 1'b1;
        ctrl.aluOp  = ALU_FUNCT;
        if (funct == FN_JREG) ctrl.jumpReg  = 1'b1;
        else                  ctrl.regWrite = 1'b1;
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
        ctrl.aluOp    = ALU_ADD;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.aluOp    = ALU_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      OP_BNE: begin
        ctrl.branchNotEq = 1'b1;
        ctrl.aluOp       = ALU_SUB;
      end
      OP_JMP:  ctrl.jump = 1'b1;
      OP_LINK: begin
        ctrl.jump     = 1'b1;
        ctrl.jal      = 1'b1;
        ctrl.regWrite = 1'b1;
      end
      OP_UPPER: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.aluOp    = ALU_UPPER;
      end
      default: known = 1'b0;
    endcase
  end

  // guards on the decoded strobes
  always_comb begin
    p_mem_excl_r3: assert (!(ctrl.memRead && ctrl.memWrite))
      else $error("memRead and memWrite both raised");
    p_flow_onehot_r5: assert ($onehot0({ctrl.branch, ctrl.branchNotEq, ctrl.jump, ctrl.jumpReg}))
      else $error("more than one control-flow strobe");
    p_jr_nowrite_r9: assert (!ctrl.jumpReg || !ctrl.regWrite)
      else $error("register jump with write enabled");
    p_unknown_idle_r10: assert (known || (ctrl == '0))
      else $error("unknown opcode raised a strobe");
  end
endmodule

// File: rtl/sc_datapath_sel.sv
module sc_datapath_sel
  import sc_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int OFFSET_W   = 16,
  parameter int INDEX_W    = 26,
  parameter int REG_ADDR_W = 5,
  parameter int LINK_REG   = 31
) (
  input  dp_strobe_t            strobes,
  input  logic                  zeroFlag,
  input  logic [DATA_W-1:0]     pcPlus4,
  input  logic [OFFSET_W-1:0]   offset,
  input  logic [INDEX_W-1:0]    index,
  input  logic [DATA_W-1:0]     regRead1,
  input  logic [REG_ADDR_W-1:0] rtField,
  input  logic [REG_ADDR_W-1:0] rdField,
  input  logic [DATA_W-1:0]     aluResult,
  input  logic [DATA_W-1:0]     memData,
  output logic [DATA_W-1:0]     nextPc,
  output logic [REG_ADDR_W-1:0] writeReg,
  output logic [DATA_W-1:0]     writeData
);
  localparam int EXT_W   = DATA_W - OFFSET_W - 2;
  localparam int UPPER_W = DATA_W - INDEX_W - 2;
  localparam logic [REG_ADDR_W-1:0] LINK_ADDR = REG_ADDR_W'(LINK_REG);

  logic [DATA_W-1:0] branchTarget, jumpTarget, seqOrBranch, afterJump;
  logic              taken;
  logic [REG_ADDR_W-1:0] fieldReg;
  logic [DATA_W-1:0]     resultData;

  // next-PC chain: branch, then jump, then register jump last
  assign branchTarget = pcPlus4 + {{EXT_W{offset[OFFSET_W-1]}}, offset, 2'b00};
  assign jumpTarget   = {pcPlus4[DATA_W-1 -: UPPER_W], index, 2'b00};
  assign taken        = (strobes.branch & zeroFlag) | (strobes.branchNotEq & ~zeroFlag);
  assign seqOrBranch  = taken ? branchTarget : pcPlus4;
  assign afterJump    = strobes.jump ? jumpTarget : seqOrBranch;
  assign nextPc       = strobes.jumpReg ? regRead1 : afterJump;

  // writeback chain: link override sits after the ordinary muxes
  assign fieldReg   = strobes.regDst ? rdField : rtField;
  assign resultData = strobes.memToReg ? memData : aluResult;
  assign writeReg   = strobes.jal ? LINK_ADDR : fieldReg;
  assign writeData  = strobes.jal ? pcPlus4 : resultData;

  always_comb begin
    p_seq_default_r10: assert ((strobes.branch | strobes.branchNotEq | strobes.jump | strobes.jumpReg)
                               || (nextPc == pcPlus4))
      else $error("next PC moved with no flow strobe");
    p_untaken_r4: assert (!(strobes.branch && !zeroFlag && !strobes.jumpReg) || (nextPc == pcPlus4))
      else $error("branch-if-equal taken on non-zero");
    p_link_r7: assert (!strobes.jal || ((writeReg == LINK_ADDR) && (writeData == pcPlus4)))
      else $error("link write not forced");
  end
endmodule

// File: rtl/sc_control_unit.sv
module sc_control_unit
  import sc_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] pcPlus4,
  input  logic              zeroFlag,
  input  logic [DATA_W-1:0] regRead1,
  input  logic [DATA_W-1:0] aluResult,
  input  logic [DATA_W-1:0] memData,
  output logic              regDst,
  output logic              aluSrc,
  output logic              memToReg,
  output logic              regWrite,
  output logic              memRead,
  output logic              memWrite,
  output logic              branch,
  output logic              branchNotEq,
  output logic              jump,
  output logic              jal,
  output logic              jumpReg,
  output logic [1:0]        aluOp,
  output logic [DATA_W-1:0] nextPc,
  output logic [4:0]        writeReg,
  output logic [DATA_W-1:0] writeData
);
  ctrl_t      ctrl;
  dp_strobe_t strobes;
  logic       unusedShamt;

  assign unusedShamt = ^instr[10:6];

  sc_main_decoder u_decoder (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign strobes = '{regDst: ctrl.regDst, memToReg: ctrl.memToReg, branch: ctrl.branch,
                     branchNotEq: ctrl.branchNotEq, jump: ctrl.jump, jal: ctrl.jal,
                     jumpReg: ctrl.jumpReg};

  sc_datapath_sel #(
    .DATA_W     (DATA_W),
    .OFFSET_W   (16),
    .INDEX_W    (26),
    .REG_ADDR_W (5),
    .LINK_REG   (31)
  ) u_datapath (
    .strobes   (strobes),
    .zeroFlag  (zeroFlag),
    .pcPlus4   (pcPlus4),
    .offset    (instr[15:0]),
    .index     (instr[25:0]),
    .regRead1  (regRead1),
    .rtField   (instr[20:16]),
    .rdField   (instr[15:11]),
    .aluResult (aluResult),
    .memData   (memData),
    .nextPc    (nextPc),
    .writeReg  (writeReg),
    .writeData (writeData)
  );

  assign regDst      = ctrl.regDst;
  assign aluSrc      = ctrl.aluSrc;
  assign memToReg    = ctrl.memToReg;
  assign regWrite    = ctrl.regWrite;
  assign memRead     = ctrl.memRead;
  assign memWrite    = ctrl.memWrite;
  assign branch      = ctrl.branch;
  assign branchNotEq = ctrl.branchNotEq;
  assign jump        = ctrl.jump;
  assign jal         = ctrl.jal;
  assign jumpReg     = ctrl.jumpReg;
  assign aluOp       = ctrl.aluOp;

  always_comb begin
    p_jr_target_r9: assert (!jumpReg || (nextPc == regRead1))
      else $error("register jump target not taken");
    p_store_nowrite_r3: assert (!memWrite || !regWrite)
      else $error("store also writes register");
  end
endmodule

// File: tb/sc_control_unit_bench.sv
`timescale 1ns/1ps
module sc_control_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr = '0, pcPlus4 = '0, regRead1 = '0, aluResult = '0, memData = '0;
  logic        zeroFlag = 1'b0;
  logic regDst, aluSrc, memToReg, regWrite, memRead, memWrite;
  logic branch, branchNotEq, jump, jal, jumpReg;
  logic [1:0]  aluOp;
  logic [31:0] nextPc, writeData;
  logic [4:0]  writeReg;

  int checks = 0, fails = 0;
  bit done = 0;

  sc_control_unit u_sc_control_unit (
    .instr(instr), .pcPlus4(pcPlus4), .zeroFlag(zeroFlag), .regRead1(regRead1),
    .aluResult(aluResult), .memData(memData), .regDst(regDst), .aluSrc(aluSrc),
    .memToReg(memToReg), .regWrite(regWrite), .memRead(memRead), .memWrite(memWrite),
    .branch(branch), .branchNotEq(branchNotEq), .jump(jump), .jal(jal),
    .jumpReg(jumpReg), .aluOp(aluOp), .nextPc(nextPc), .writeReg(writeReg),
    .writeData(writeData)
  );

  function automatic string tagOf(input logic [31:0] ins);
    case (ins[31:26])
      6'b000000: return (ins[5:0] == 6'b001000) ? "R9" : "R1";
      6'b100011: return "R2";
      6'b101011: return "R3";
      6'b000100: return "R4";
      6'b000101: return "R5";
      6'b000010: return "R6";
      6'b000011: return "R7";
      6'b001111: return "R8";
      default:   return "R10";
    endcase
  endfunction

  // behavioural reference built from the requirement list
  task automatic model(output logic [12:0] eCtl, output logic [31:0] eNpc,
                       output logic [4:0] eWr, output logic [31:0] eWd);
    int rd = 0, as = 0, m2r = 0, rw = 0, mr = 0, mw = 0, br = 0, bn = 0, jp = 0, lk = 0, jr = 0, op = 0;
    logic [31:0] tgtB, tgtJ;
    tgtB = pcPlus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
    tgtJ = {pcPlus4[31:28], instr[25:0], 2'b00};
    eNpc = pcPlus4;
    case (tagOf(instr))
      "R1": begin rd = 1; rw = 1; op = 2; end
      "R9": begin rd = 1; jr = 1; op = 2; eNpc = regRead1; end
      "R2": begin as = 1; m2r = 1; rw = 1; mr = 1; end
      "R3": begin as = 1; mw = 1; end
      "R4": begin br = 1; op = 1; if (zeroFlag) eNpc = tgtB; end
      "R5": begin bn = 1; op = 1; if (!zeroFlag) eNpc = tgtB; end
      "R6": begin jp = 1; eNpc = tgtJ; end
      "R7": begin jp = 1; lk = 1; rw = 1; eNpc = tgtJ; end
      "R8": begin as = 1; rw = 1; op = 3; end
      default: ;
    endcase
    eCtl = {rd[0], as[0], m2r[0], rw[0], mr[0], mw[0], br[0], bn[0], jp[0], lk[0], jr[0], op[1:0]};
    eWr  = lk ? 5'd31 : (rd ? instr[15:11] : instr[20:16]);
    eWd  = lk ? pcPlus4 : (m2r ? memData : aluResult);
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] pc4, input logic z);
    logic [12:0] eCtl, aCtl;
    logic [31:0] eNpc, eWd;
    logic [4:0]  eWr;
    string tag;
    @(posedge clk); #1;
    instr = ins; pcPlus4 = pc4; zeroFlag = z;
    regRead1 = $urandom; aluResult = $urandom; memData = $urandom;
    @(negedge clk);
    model(eCtl, eNpc, eWr, eWd);
    tag = tagOf(ins);
    aCtl = {regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch, branchNotEq,
            jump, jal, jumpReg, aluOp};
    checks++;
    if (aCtl !== eCtl || nextPc !== eNpc || writeReg !== eWr || writeData !== eWd) begin
      fails++;
      $display("FAIL %s instr=%h ctl=%b/%b npc=%h/%h wr=%0d/%0d wd=%h/%h (actual/expected)",
               tag, ins, aCtl, eCtl, nextPc, eNpc, writeReg, eWr, writeData, eWd);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op);
    return {op, 26'($urandom)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset-state style idle check, R10: unused opcode leaves everything low
    apply({6'b111111, 26'h0}, 32'h0000_0004, 1'b0);
    // R1 register ops with various fields
    apply({6'b000000, 5'd3, 5'd7, 5'd12, 5'd0, 6'b100000}, 32'h0040_0010, 1'b0);
    apply({6'b000000, 5'd31, 5'd1, 5'd30, 5'd4, 6'b000000}, 32'h0040_0020, 1'b1);
    // R9 register jump, with zero flag both ways
    apply({6'b000000, 5'd5, 15'h0, 6'b001000}, 32'h1000_0000, 1'b1);
    apply({6'b000000, 5'd9, 15'h7fff, 6'b001000}, 32'h2000_0004, 1'b0);
    // R2 load, R3 store
    apply({6'b100011, 5'd2, 5'd8, 16'hfffc}, 32'h0000_1000, 1'b0);
    apply({6'b101011, 5'd2, 5'd9, 16'h0010}, 32'h0000_1004, 1'b1);
    // R4 branch-if-equal: taken forward, taken backward, not taken
    apply({6'b000100, 5'd1, 5'd2, 16'h0003}, 32'h0000_2000, 1'b1);
    apply({6'b000100, 5'd1, 5'd2, 16'hfffe}, 32'h0000_2000, 1'b1);
    apply({6'b000100, 5'd1, 5'd2, 16'h0003}, 32'h0000_2000, 1'b0);
    // R5 branch-if-not-equal: taken and not taken
    apply({6'b000101, 5'd1, 5'd2, 16'h8000}, 32'h0004_0000, 1'b0);
    apply({6'b000101, 5'd1, 5'd2, 16'h0040}, 32'h0004_0000, 1'b1);
    // R6 jump, R7 link jump across upper-bit regions
    apply({6'b000010, 26'h3ff_ffff}, 32'hf000_0008, 1'b0);
    apply({6'b000011, 26'h000_0123}, 32'ha000_0100, 1'b1);
    apply({6'b000011, 26'h2aa_aaaa}, 32'h5fff_fffc, 1'b0);
    // R8 upper immediate
    apply({6'b001111, 5'd0, 5'd17, 16'hbeef}, 32'h0000_3000, 1'b1);
    // R10 sweep of every opcode with both zero values
    for (int op = 0; op < 64; op++) begin
      apply(mk(6'(op)), $urandom, 1'b0);
      apply(mk(6'(op)), $urandom, 1'b1);
    end
    // mixed random stream over the supported set
    for (int i = 0; i < 300; i++) begin
      logic [5:0] ops [8] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100,
                              6'b000101, 6'b000010, 6'b000011, 6'b001111};
      logic [31:0] ins;
      ins = mk(ops[$urandom % 8]);
      if (ins[31:26] == 6'b000000 && ($urandom % 3 == 0)) ins[5:0] = 6'b001000;
      apply(ins, $urandom, 1'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule